// File: doc/BRIEF.md
# I2C Bit-Timing Generator

This block turns bus-level commands from an I2C master's byte engine into the SCL waveform and the SDA drive level, using three 32-bit timing words. Each word packs two 16-bit fields: the SCL high and low periods, an offset inside the low phase where the next SDA value is driven, an offset inside the high phase where the incoming SDA line is sampled, the hold time after a START before SCL falls, and the idle time the bus must stay free after a STOP. The hardware adds a fixed number of clock cycles to both programmed phase counts, so the values software writes are the desired phase lengths minus that overhead.

The byte engine issues START, STOP and single-bit commands on a valid/ready handshake. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a bit, START or STOP waveform is in progress and while the bus-free window runs, which is how the generator holds the engine back. There is no back-pressure on the result side: `done_o` is a single-cycle strobe that the engine must take when it fires. Between commands SCL is parked either low, which stretches the clock until the engine is ready, or high, as the last bit command requested.

Outputs are open-drain intents: a 1 on `scl_o` or `sda_o` means release the line and a 0 means pull it low. `sda_in` is the observed level of the SDA line.

Top module: `i2cbt_gen`

## Requirements
- R1: After reset, and whenever no transaction is open, `scl_o` and `sda_o` are 1, `busy_o` is 0, `cmd_ready` is 1 and neither strobe nor `done_o` is active.
- R2: Field layout. Word 0: bits 31:16 are the high count and bits 15:0 are the sample offset. Word 1: bits 31:16 are the low count and bits 15:0 are the drive offset. Word 2: bits 31:16 are the bus-free count and bits 15:0 are the lead-in count.
- R3: An SCL low phase lasts the low count plus 2 cycles. `drive_stb_o` is high in the low-phase cycle whose index, counted from 0, equals the drive offset, and `sda_o` shows the new value from the next cycle on.
- R4: An SCL high phase lasts the high count plus 7 cycles. `sample_stb_o` is high in the high-phase cycle whose index equals the sample offset, and `sda_in` from that cycle is presented on `rx_bit_o` while `done_o` is high at the end of a bit.
- R5: A START accepted on an idle bus pulls SDA low with SCL high for max(lead-in, 1) cycles, then SCL goes low. A START accepted while parked (a repeated START) first runs a low phase that releases SDA and a full high phase, then performs the same sequence.
- R6: A STOP runs a low phase that drives SDA to 0 and a full high phase with SDA at 0. SDA is then released while SCL stays high.
- R7: After a STOP releases SDA, `busy_o` stays 1 and `cmd_ready` stays 0 for max(bus-free, 1) cycles. The block then returns to idle.
- R8: At the end of a bit command with `cmd_retain` set, SCL stays low until the next command. Without it, SCL stays high.
- R9: `done_o` is a one-cycle pulse, given once per START, STOP or bit. For a bit it is in the cycle after the high phase ends, for a STOP in the cycle SDA is released, and for a START in the first cycle of SCL low.
- R10: Command encoding on `cmd_op`: 2'b00 is a bit, 2'b01 is START, 2'b10 is STOP and 2'b11 acts as a bit. On an idle bus only START has an effect: a bit or STOP is accepted and discarded, with the lines left released and no `done_o`.
- R11: `cmd_ready` is high only when the bus is idle (not during the bus-free window) or parked between commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word0 | input | 32 | High count and sample offset |
| cfg_word1 | input | 32 | Low count and drive offset |
| cfg_word2 | input | 32 | Bus-free count and lead-in count |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Generator can take a command |
| cmd_op | input | 2 | Command code (see R10) |
| cmd_bit | input | 1 | SDA value for a bit command (1 = release) |
| cmd_retain | input | 1 | Park SCL low after this bit |
| sda_in | input | 1 | Observed SDA line level |
| scl_o | output | 1 | SCL intent, 0 = pull low |
| sda_o | output | 1 | SDA intent, 0 = pull low |
| drive_stb_o | output | 1 | Cycle in which a new SDA value is launched |
| sample_stb_o | output | 1 | Cycle in which `sda_in` is captured |
| done_o | output | 1 | Command finished strobe |
| rx_bit_o | output | 1 | Sampled SDA bit, valid with `done_o` |
| busy_o | output | 1 | Transaction open or bus-free window running |

## Verification
The assertions check, on every cycle, the properties that hold for any timing words: drive strobes fall only in SCL-low time and sample strobes only in SCL-high time; SDA falls with SCL high only at a START and then stays low; SDA rises with SCL high only at a STOP, together with `done_o`; `done_o` never lasts two cycles; and released lines and ready go together with an idle bus. Exact phase lengths, the added overhead cycles, the positions of the programmed offsets, the field layout, the retain-clock parking level, the length of the bus-free window and the discarding of commands on an idle bus depend on the programmed values. Only the bench's directed scenarios, run with two different sets of timing words, can show these.

// File: rtl/i2cbt_pkg.sv
package i2cbt_pkg;

  // command codes presented on cmd_op
  typedef enum logic [1:0] {
    OP_BIT   = 2'b00,
    OP_START = 2'b01,
    OP_STOP  = 2'b10,
    OP_ALT   = 2'b11
  } op_e;

  // sequencer states; the timer derives the phase length from these
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_PARK,
    ST_FREE
  } st_e;

  localparam int NUM_WORDS = 3;

endpackage

// File: rtl/i2cbt_unpack.sv
module i2cbt_unpack
  import i2cbt_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int FIELD_W = 16
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  words,
  output logic [NUM_WORDS-1:0][FIELD_W-1:0] upper,
  output logic [NUM_WORDS-1:0][FIELD_W-1:0] lower
);

  // each word carries one field in its top half and one in its bottom half
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    assign upper[g] = words[g][WORD_W-1 -: FIELD_W];
    assign lower[g] = words[g][FIELD_W-1:0];
  end

endmodule

// File: rtl/i2cbt_timer.sv
module i2cbt_timer
  import i2cbt_pkg::*;
#(
  parameter int FIELD_W    = 16,
  parameter int LOW_EXTRA  = 2,
  parameter int HIGH_EXTRA = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  st_e                phase,
  input  logic [FIELD_W-1:0] lo_cnt,
  input  logic [FIELD_W-1:0] tx_off,
  input  logic [FIELD_W-1:0] hi_cnt,
  input  logic [FIELD_W-1:0] rx_off,
  input  logic [FIELD_W-1:0] lead_cnt,
  input  logic [FIELD_W-1:0] free_cnt,
  output logic               at_end,
  output logic               at_mark
);

  // one spare bit so a full count plus overhead cannot wrap
  localparam int CNT_W = FIELD_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] mark;
  logic             mark_en;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  always_comb begin
    len     = CNT_W'(1);
    mark    = '0;
    mark_en = 1'b0;
    unique case (phase)
      ST_LOW: begin
        len     = {1'b0, lo_cnt} + CNT_W'(LOW_EXTRA);
        mark    = {1'b0, tx_off};
        mark_en = 1'b1;
      end
      ST_HIGH: begin
        len     = {1'b0, hi_cnt} + CNT_W'(HIGH_EXTRA);
        mark    = {1'b0, rx_off};
        mark_en = 1'b1;
      end
      ST_LEAD: len = (lead_cnt == '0) ? CNT_W'(1) : {1'b0, lead_cnt};
      ST_FREE: len = (free_cnt == '0) ? CNT_W'(1) : {1'b0, free_cnt};
      default: len = CNT_W'(1);
    endcase
  end

  assign at_end  = (cnt == len - CNT_W'(1));
  assign at_mark = mark_en && (cnt == mark);

endmodule

// File: rtl/i2cbt_seq.sv
module i2cbt_seq
  import i2cbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       cmd_retain,
  input  logic       sda_in,
  input  logic       at_end,
  input  logic       at_mark,
  output st_e        phase,
  output logic       tmr_clr,
  output logic       scl_o,
  output logic       sda_o,
  output logic       drive_stb_o,
  output logic       sample_stb_o,
  output logic       done_o,
  output logic       rx_bit_o,
  output logic       busy_o
);

  st_e  state, nxt;
  op_e  op_q;
  logic bit_q, ret_q, sda_q, rx_q, park_lo_q, done_q;
  logic accept;
  op_e  op_in;

  assign op_in     = op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE) || (state == ST_PARK);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (accept && op_in == OP_START) nxt = ST_LEAD;
      ST_PARK: if (accept) nxt = ST_LOW;
      ST_LOW:  if (at_end) nxt = ST_HIGH;
      ST_HIGH: if (at_end) begin
        if (op_q == OP_STOP)       nxt = ST_FREE;
        else if (op_q == OP_START) nxt = ST_LEAD;
        else                       nxt = ST_PARK;
      end
      ST_LEAD: if (at_end) nxt = ST_PARK;
      ST_FREE: if (at_end) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  // the phase counter restarts on every state change
  assign tmr_clr = (nxt != state);
  assign phase   = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= OP_BIT;
      bit_q     <= 1'b1;
      ret_q     <= 1'b0;
      sda_q     <= 1'b1;
      rx_q      <= 1'b0;
      park_lo_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept && op_in == OP_START) sda_q <= 1'b0;
        ST_PARK: if (accept) begin
          op_q  <= op_in;
          ret_q <= cmd_retain;
          unique case (op_in)
            OP_START: bit_q <= 1'b1;
            OP_STOP:  bit_q <= 1'b0;
            default:  bit_q <= cmd_bit;
          endcase
        end
        ST_LOW: if (at_mark) sda_q <= bit_q;
        ST_HIGH: begin
          if (at_mark) rx_q <= sda_in;
          if (at_end) begin
            unique case (op_q)
              OP_STOP: begin
                sda_q  <= 1'b1;
                done_q <= 1'b1;
              end
              OP_START: sda_q <= 1'b0;
              default: begin
                done_q    <= 1'b1;
                park_lo_q <= ret_q;
              end
            endcase
          end
        end
        ST_LEAD: if (at_end) begin
          done_q    <= 1'b1;
          park_lo_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign scl_o        = !((state == ST_LOW) || (state == ST_PARK && park_lo_q));
  assign sda_o        = sda_q;
  assign drive_stb_o  = (state == ST_LOW) && at_mark;
  assign sample_stb_o = (state == ST_HIGH) && at_mark;
  assign done_o       = done_q;
  assign rx_bit_o     = rx_q;
  assign busy_o       = (state != ST_IDLE);

endmodule

// File: rtl/i2cbt_gen.sv
module i2cbt_gen
  import i2cbt_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIELD_W    = 16,
  parameter int LOW_EXTRA  = 2,
  parameter int HIGH_EXTRA = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_word0,
  input  logic [WORD_W-1:0] cfg_word1,
  input  logic [WORD_W-1:0] cfg_word2,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_bit,
  input  logic              cmd_retain,
  input  logic              sda_in,
  output logic              scl_o,
  output logic              sda_o,
  output logic              drive_stb_o,
  output logic              sample_stb_o,
  output logic              done_o,
  output logic              rx_bit_o,
  output logic              busy_o
);

  localparam int IDX_HIGH = 0;
  localparam int IDX_LOW  = 1;
  localparam int IDX_BUS  = 2;

  logic [NUM_WORDS-1:0][WORD_W-1:0]  words;
  logic [NUM_WORDS-1:0][FIELD_W-1:0] upper, lower;
  st_e  phase;
  logic tmr_clr, at_end, at_mark;

  assign words[IDX_HIGH] = cfg_word0;
  assign words[IDX_LOW]  = cfg_word1;
  assign words[IDX_BUS]  = cfg_word2;

  i2cbt_unpack #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_unpack (
    .words (words),
    .upper (upper),
    .lower (lower)
  );

  i2cbt_timer #(
    .FIELD_W    (FIELD_W),
    .LOW_EXTRA  (LOW_EXTRA),
    .HIGH_EXTRA (HIGH_EXTRA)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .phase    (phase),
    .lo_cnt   (upper[IDX_LOW]),
    .tx_off   (lower[IDX_LOW]),
    .hi_cnt   (upper[IDX_HIGH]),
    .rx_off   (lower[IDX_HIGH]),
    .lead_cnt (lower[IDX_BUS]),
    .free_cnt (upper[IDX_BUS]),
    .at_end   (at_end),
    .at_mark  (at_mark)
  );

  i2cbt_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_op       (cmd_op),
    .cmd_bit      (cmd_bit),
    .cmd_retain   (cmd_retain),
    .sda_in       (sda_in),
    .at_end       (at_end),
    .at_mark      (at_mark),
    .phase        (phase),
    .tmr_clr      (tmr_clr),
    .scl_o        (scl_o),
    .sda_o        (sda_o),
    .drive_stb_o  (drive_stb_o),
    .sample_stb_o (sample_stb_o),
    .done_o       (done_o),
    .rx_bit_o     (rx_bit_o),
    .busy_o       (busy_o)
  );

endmodule

// File: rtl/i2cbt_gen_chk.sv
module i2cbt_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic scl_o,
  input logic sda_o,
  input logic drive_stb_o,
  input logic sample_stb_o,
  input logic done_o,
  input logic busy_o
);

  // R3: new SDA data is launched only while SCL is held low
  a_r3_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    drive_stb_o |-> !scl_o);

  // R4: SDA is captured only while SCL is released
  a_r4_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb_o |-> scl_o);

  // R1: an idle bus has both lines released and takes commands
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (scl_o && sda_o && cmd_ready && !done_o));

  // R5: SDA falling under a high SCL is a START and is held at least a cycle
  a_r5_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_o) && scl_o && $past(scl_o)) |=> !sda_o);

  // R6: SDA rising under a high SCL is a STOP and completes it
  a_r6_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_o) && scl_o && $past(scl_o)) |-> (done_o && busy_o));

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11: commands are refused only while a transaction is open
  a_r11_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> busy_o);

endmodule

bind i2cbt_gen i2cbt_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_ready    (cmd_ready),
  .scl_o        (scl_o),
  .sda_o        (sda_o),
  .drive_stb_o  (drive_stb_o),
  .sample_stb_o (sample_stb_o),
  .done_o       (done_o),
  .busy_o       (busy_o)
);

// File: tb/i2cbt_gen_bench.sv
module i2cbt_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TR = 40;
  localparam logic [1:0] OPB = 2'b00;
  localparam logic [1:0] OPS = 2'b01;
  localparam logic [1:0] OPP = 2'b10;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] w0, w1, w2;
  logic cmd_valid, cmd_ready, cmd_bit, cmd_retain, sda_in;
  logic [1:0] cmd_op;
  logic scl_o, sda_o, drive_stb_o, sample_stb_o, done_o, rx_bit_o, busy_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cbt_gen u_i2cbt_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_word0(w0), .cfg_word1(w1), .cfg_word2(w2),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .cmd_retain(cmd_retain), .sda_in(sda_in),
    .scl_o(scl_o), .sda_o(sda_o), .drive_stb_o(drive_stb_o),
    .sample_stb_o(sample_stb_o), .done_o(done_o), .rx_bit_o(rx_bit_o),
    .busy_o(busy_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic scl_tr[TR], sda_tr[TR], drv_tr[TR], smp_tr[TR];
  logic done_tr[TR], rx_tr[TR], busy_tr[TR], rdy_tr[TR];

  int txo, rxo, nl, nh, ll, fl;

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int first_eq(input logic tr[TR], input logic v, input int from);
    for (int j = from; j < TR; j++) if (tr[j] == v) return j;
    return -1;
  endfunction

  function automatic int count_ones(input logic tr[TR]);
    int c = 0;
    for (int j = 0; j < TR; j++) if (tr[j]) c++;
    return c;
  endfunction

  // expected lengths are derived from the requirement text, not from the RTL
  task automatic set_cfg(input int hi, input int rx, input int lo, input int tx,
                         input int fr, input int ld);
    w0 = {16'(hi), 16'(rx)};
    w1 = {16'(lo), 16'(tx)};
    w2 = {16'(fr), 16'(ld)};
    txo = tx; rxo = rx;
    nl = lo + 2; nh = hi + 7;
    ll = (ld == 0) ? 1 : ld;
    fl = (fr == 0) ? 1 : fr;
  endtask

  // present one command, then record TR cycles; index 0 is the cycle after acceptance
  task automatic issue(input logic [1:0] op, input logic b, input logic ret);
    @(negedge clk);
    check("R11", "ready before command", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b; cmd_retain = ret;
    @(posedge clk);
    for (int j = 0; j < TR; j++) begin
      @(negedge clk);
      scl_tr[j] = scl_o;   sda_tr[j] = sda_o;
      drv_tr[j] = drive_stb_o; smp_tr[j] = sample_stb_o;
      done_tr[j] = done_o; rx_tr[j] = rx_bit_o;
      busy_tr[j] = busy_o; rdy_tr[j] = cmd_ready;
      if (j == 0) cmd_valid = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "scl after reset", int'(scl_o), 1);
    check("R1", "sda after reset", int'(sda_o), 1);
    check("R1", "busy after reset", int'(busy_o), 0);
    check("R1", "ready after reset", int'(cmd_ready), 1);
    check("R1", "done after reset", int'(done_o), 0);
  endtask

  task automatic t_ignored(input logic [1:0] op);
    issue(op, 1'b0, 1'b1);
    check("R10", "scl never low", first_eq(scl_tr, 1'b0, 0), -1);
    check("R10", "sda never low", first_eq(sda_tr, 1'b0, 0), -1);
    check("R10", "no done", count_ones(done_tr), 0);
    check("R10", "never busy", count_ones(busy_tr), 0);
  endtask

  task automatic t_start_idle();
    issue(OPS, 1'b0, 1'b0);
    check("R5", "sda low at once", int'(sda_tr[0]), 0);
    check("R5", "scl falls after lead-in", first_eq(scl_tr, 1'b0, 0), ll);
    check("R5", "sda held low at scl fall", int'(sda_tr[ll]), 0);
    check("R9", "start done position", first_eq(done_tr, 1'b1, 0), ll);
    check("R9", "start single done", count_ones(done_tr), 1);
  endtask

  task automatic t_bit(input string req, input logic b, input logic rxv, input logic ret);
    sda_in = rxv;
    issue(OPB, b, ret);
    check({req, " R3"}, "drive strobe position", first_eq(drv_tr, 1'b1, 0), txo);
    check({req, " R3"}, "sda after drive", int'(sda_tr[txo+1]), int'(b));
    check({req, " R3"}, "low phase length", first_eq(scl_tr, 1'b1, 0), nl);
    check({req, " R4"}, "sample strobe position", first_eq(smp_tr, 1'b1, 0), nl + rxo);
    check({req, " R4"}, "high phase length", first_eq(done_tr, 1'b1, 0), nl + nh);
    check({req, " R4"}, "received bit", int'(rx_tr[nl+nh]), int'(rxv));
    check("R8", "parked scl level", int'(scl_tr[nl+nh+2]), int'(!ret));
    check("R9", "bit single done", count_ones(done_tr), 1);
    sda_in = 1'b1;
  endtask

  task automatic t_rstart();
    issue(OPS, 1'b0, 1'b0);
    check("R5", "sda released in low phase", int'(sda_tr[txo+1]), 1);
    check("R5", "scl rises after low phase", first_eq(scl_tr, 1'b1, 0), nl);
    check("R5", "sda falls after high phase", first_eq(sda_tr, 1'b0, nl), nl + nh);
    check("R5", "scl falls after lead-in", first_eq(scl_tr, 1'b0, nl), nl + nh + ll);
    check("R9", "repeated start done", first_eq(done_tr, 1'b1, 0), nl + nh + ll);
  endtask

  task automatic t_stop();
    issue(OPP, 1'b1, 1'b0);
    check("R6", "sda low in low phase", int'(sda_tr[txo+1]), 0);
    check("R6", "scl rises", first_eq(scl_tr, 1'b1, 0), nl);
    check("R6", "sda low late in high phase", int'(sda_tr[nl+nh-1]), 0);
    check("R6", "stop done position", first_eq(done_tr, 1'b1, 0), nl + nh);
    check("R6", "sda released", int'(sda_tr[nl+nh]), 1);
    check("R6", "scl high at release", int'(scl_tr[nl+nh]), 1);
    check("R7", "ready low in bus-free", int'(rdy_tr[nl+nh+fl-1]), 0);
    check("R7", "busy in bus-free", int'(busy_tr[nl+nh+fl-1]), 1);
    check("R7", "ready after bus-free", int'(rdy_tr[nl+nh+fl]), 1);
    check("R7", "idle after bus-free", int'(busy_tr[nl+nh+fl]), 0);
    check("R9", "stop single done", count_ones(done_tr), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = OPB; cmd_bit = 1'b1;
    cmd_retain = 1'b0; sda_in = 1'b1;
    set_cfg(2, 3, 3, 1, 6, 4);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_ignored(OPB);
    t_ignored(OPP);
    t_start_idle();
    t_bit("R3", 1'b1, 1'b0, 1'b1);
    t_bit("R4", 1'b0, 1'b1, 1'b0);
    t_bit("R8", 1'b0, 1'b1, 1'b1);
    t_rstart();
    t_stop();
    t_start_idle();
    t_stop();
    // second timing set: different field values expose any field swap
    set_cfg(0, 6, 6, 5, 0, 0);
    t_start_idle();
    t_bit("R2", 1'b1, 1'b1, 1'b1);
    t_bit("R2", 1'b0, 1'b0, 1'b1);
    t_stop();
    t_reset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule